// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This combinational control block sits beside the datapath of a five-stage in-order integer pipeline (fetch, decode, execute, memory access, write-back). It looks at the register numbers, write enables and load/store flags held in the decode stage and in the three pipeline registers behind it. From these it selects where each ALU operand comes from, and where the data of a store in the memory stage comes from. It also decides whether fetch and decode must hold for one cycle.

Most read-after-write dependences are resolved by bypassing. One case cannot be bypassed: a load followed at once by an instruction that needs the loaded value as an ALU operand. For that case the unit freezes the program counter and the fetch/decode register, and it turns the instruction entering execute into a bubble. A store's data register is not needed until the memory stage. A load feeding the data of a store behind it is therefore bypassed from write-back into the memory stage, with no stall.

Top module: `hazard_fwd_unit`

## Requirements
- R1: When the EX/MEM producer has its write enable set and a nonzero destination equal to an execute-stage source, that operand's select (`fwd_a` for rs, `fwd_b` for rt) is 2'b10. The select is never 2'b11.
- R2: When only the MEM/WB producer has its write enable set and a nonzero destination matching the source, the select is 2'b01. This includes a load two slots ahead. Otherwise the select is 2'b00, meaning the register file.
- R3: When both producers match the same source, the select is 2'b10, so the younger result wins.
- R4: Register 0 never causes a forward, a store-data forward or a stall, even with the write enables set.
- R5: A producer whose write enable is clear never causes a forward.
- R6: If ID/EX holds a load with its write enable set and a nonzero destination, and the decode instruction reads that register in execute through rs or rt, then `pc_we`=0, `ifid_we`=0 and `idex_bubble`=1.
- R7: A decode-stage store whose data register (rt, with `id_rt_ex`=0) matches a load in ID/EX causes no stall.
- R8: A non-load producer in ID/EX never causes a stall.
- R9: `fwd_sd` is 1 only when EX/MEM holds a store and MEM/WB writes a nonzero register equal to the store's data register. In that case the write-back result replaces the store data. Otherwise `fwd_sd` is 0.
- R10: Without a stall, `pc_we`=1, `ifid_we`=1 and `idex_bubble`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | REG_AW | rs of the decode-stage instruction |
| id_rt | input | REG_AW | rt of the decode-stage instruction |
| id_rs_ex | input | 1 | decode instruction reads rs in execute |
| id_rt_ex | input | 1 | decode instruction reads rt in execute (0 for store data) |
| idex_rs | input | REG_AW | rs held in ID/EX |
| idex_rt | input | REG_AW | rt held in ID/EX |
| idex_rd | input | REG_AW | destination held in ID/EX |
| idex_wen | input | 1 | ID/EX instruction writes a register |
| idex_load | input | 1 | ID/EX instruction is a load |
| exmem_rd | input | REG_AW | destination held in EX/MEM |
| exmem_rt | input | REG_AW | store data register held in EX/MEM |
| exmem_wen | input | 1 | EX/MEM instruction writes a register |
| exmem_store | input | 1 | EX/MEM instruction is a store |
| memwb_rd | input | REG_AW | destination held in MEM/WB |
| memwb_wen | input | 1 | MEM/WB instruction writes a register |
| fwd_a | output | 2 | ALU operand A source select |
| fwd_b | output | 2 | ALU operand B source select |
| fwd_sd | output | 1 | store data from the write-back result |
| pc_we | output | 1 | program counter write enable |
| ifid_we | output | 1 | IF/ID register write enable |
| idex_bubble | output | 1 | clear the control bits written into ID/EX |

## Verification
Every output is a pure function of the present inputs, so each result is due in the same cycle as its stimulus, with no register on the path. The bench changes inputs on the falling clock edge and reads outputs one nanosecond later, well before the next rising edge. Each scenario therefore sees settled values, and nothing depends on the order of processes at an edge.

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_rs_ex,
  input  logic              id_rt_ex,
  input  logic [REG_AW-1:0] idex_rs,
  input  logic [REG_AW-1:0] idex_rt,
  input  logic [REG_AW-1:0] idex_rd,
  input  logic              idex_wen,
  input  logic              idex_load,
  input  logic [REG_AW-1:0] exmem_rd,
  input  logic [REG_AW-1:0] exmem_rt,
  input  logic              exmem_wen,
  input  logic              exmem_store,
  input  logic [REG_AW-1:0] memwb_rd,
  input  logic              memwb_wen,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              fwd_sd,
  output logic              pc_we,
  output logic              ifid_we,
  output logic              idex_bubble
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic em_live, mw_live, ld_live, load_use;

  assign em_live = exmem_wen && (exmem_rd != ZERO_REG);
  assign mw_live = memwb_wen && (memwb_rd != ZERO_REG);
  assign ld_live = idex_load && idex_wen && (idex_rd != ZERO_REG);

  function automatic logic [1:0] pick(input logic [REG_AW-1:0] src,
                                      input logic em_ok, input logic mw_ok,
                                      input logic [REG_AW-1:0] em_rd,
                                      input logic [REG_AW-1:0] mw_rd);
    if (em_ok && em_rd == src)      pick = 2'b10;
    else if (mw_ok && mw_rd == src) pick = 2'b01;
    else                            pick = 2'b00;
  endfunction

  assign fwd_a = pick(idex_rs, em_live, mw_live, exmem_rd, memwb_rd);
  assign fwd_b = pick(idex_rt, em_live, mw_live, exmem_rd, memwb_rd);

  assign fwd_sd = exmem_store && mw_live && (memwb_rd == exmem_rt);

  assign load_use = ld_live &&
                    ((id_rs_ex && idex_rd == id_rs) ||
                     (id_rt_ex && idex_rd == id_rt));

  assign pc_we       = !load_use;
  assign ifid_we     = !load_use;
  assign idex_bubble = load_use;
endmodule

module hazard_fwd_unit_chk #(
  parameter int REG_AW = 5
) (
  input logic [REG_AW-1:0] idex_rs,
  input logic [REG_AW-1:0] idex_rd,
  input logic              idex_load,
  input logic [REG_AW-1:0] exmem_rd,
  input logic              exmem_wen,
  input logic              exmem_store,
  input logic [REG_AW-1:0] memwb_rd,
  input logic              memwb_wen,
  input logic [1:0]        fwd_a,
  input logic [1:0]        fwd_b,
  input logic              fwd_sd,
  input logic              pc_we,
  input logic              ifid_we,
  input logic              idex_bubble
);
  logic known;
  assign known = !$isunknown({idex_rs, idex_rd, idex_load, exmem_rd, exmem_wen,
                              exmem_store, memwb_rd, memwb_wen, fwd_a, fwd_b,
                              fwd_sd, pc_we, ifid_we, idex_bubble});

  always_comb begin
    if (known) begin
      p_sel_legal_r1: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
      p_young_wins_r3: assert (!(exmem_wen && exmem_rd != '0 && exmem_rd == idex_rs)
                               || fwd_a == 2'b10);
      p_zero_quiet_r4: assert (idex_rs != '0 || fwd_a == 2'b00);
      p_idle_no_fwd_r5: assert (exmem_wen || memwb_wen || (fwd_a == 2'b00 && fwd_b == 2'b00));
      p_alu_no_stall_r8: assert (idex_load || pc_we);
      p_hold_pair_r10: assert (pc_we == ifid_we && idex_bubble == !pc_we);
      p_sd_store_only_r9: assert (exmem_store || !fwd_sd);
      p_sd_zero_r4: assert (memwb_rd != '0 || !fwd_sd);
    end
  end
endmodule

bind hazard_fwd_unit hazard_fwd_unit_chk #(.REG_AW(REG_AW)) u_chk (
  .idex_rs(idex_rs), .idex_rd(idex_rd), .idex_load(idex_load),
  .exmem_rd(exmem_rd), .exmem_wen(exmem_wen), .exmem_store(exmem_store),
  .memwb_rd(memwb_rd), .memwb_wen(memwb_wen),
  .fwd_a(fwd_a), .fwd_b(fwd_b), .fwd_sd(fwd_sd),
  .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble)
);

// File: tb/tb_hazard_fwd_unit.sv
module tb_hazard_fwd_unit;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] id_rs, id_rt, idex_rs, idex_rt, idex_rd, exmem_rd, exmem_rt, memwb_rd;
  logic id_rs_ex, id_rt_ex, idex_wen, idex_load, exmem_wen, exmem_store, memwb_wen;
  logic [1:0] fwd_a, fwd_b;
  logic fwd_sd, pc_we, ifid_we, idex_bubble;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  hazard_fwd_unit #(.REG_AW(AW)) dut (
    .id_rs(id_rs), .id_rt(id_rt), .id_rs_ex(id_rs_ex), .id_rt_ex(id_rt_ex),
    .idex_rs(idex_rs), .idex_rt(idex_rt), .idex_rd(idex_rd),
    .idex_wen(idex_wen), .idex_load(idex_load),
    .exmem_rd(exmem_rd), .exmem_rt(exmem_rt), .exmem_wen(exmem_wen),
    .exmem_store(exmem_store), .memwb_rd(memwb_rd), .memwb_wen(memwb_wen),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .fwd_sd(fwd_sd),
    .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic clr();
    @(negedge clk);
    {id_rs, id_rt, idex_rs, idex_rt, idex_rd, exmem_rd, exmem_rt, memwb_rd} = '0;
    {id_rs_ex, id_rt_ex, idex_wen, idex_load, exmem_wen, exmem_store, memwb_wen} = '0;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic stall_exp(input string req, input bit st);
    chk({req, " pc_we"}, pc_we, !st);
    chk({req, " ifid_we"}, ifid_we, !st);
    chk({req, " bubble"}, idex_bubble, st);
  endtask

  task automatic t_idle();
    clr(); settle();
    chk("R10 idle fwd_a", fwd_a, 0);
    chk("R10 idle fwd_b", fwd_b, 0);
    chk("R10 idle fwd_sd", fwd_sd, 0);
    stall_exp("R10 idle", 0);
  endtask

  task automatic t_exmem();
    clr(); idex_rs = 3; idex_rt = 4; exmem_rd = 3; exmem_wen = 1; settle();
    chk("R1 rs from exmem", fwd_a, 2);
    chk("R1 rt untouched", fwd_b, 0);
    exmem_rd = 4; settle();
    chk("R1 rt from exmem", fwd_b, 2);
    chk("R1 rs back to rf", fwd_a, 0);
  endtask

  task automatic t_memwb();
    clr(); idex_rs = 6; idex_rt = 4; memwb_rd = 4; memwb_wen = 1; settle();
    chk("R2 rt from memwb", fwd_b, 1);
    chk("R2 rs from rf", fwd_a, 0);
    idex_load = 0; id_rs = 12; id_rs_ex = 1; memwb_rd = 12; idex_rs = 12; settle();
    chk("R2 load two ahead fwd", fwd_a, 1);
    stall_exp("R2 load two ahead", 0);
  endtask

  task automatic t_priority();
    clr(); idex_rs = 5; idex_rt = 5; exmem_rd = 5; memwb_rd = 5;
    exmem_wen = 1; memwb_wen = 1; settle();
    chk("R3 rs younger wins", fwd_a, 2);
    chk("R3 rt younger wins", fwd_b, 2);
  endtask

  task automatic t_zero();
    clr(); exmem_wen = 1; memwb_wen = 1; idex_wen = 1; idex_load = 1;
    id_rs_ex = 1; id_rt_ex = 1; exmem_store = 1; settle();
    chk("R4 zero fwd_a", fwd_a, 0);
    chk("R4 zero fwd_b", fwd_b, 0);
    chk("R4 zero fwd_sd", fwd_sd, 0);
    stall_exp("R4 zero", 0);
  endtask

  task automatic t_nowen();
    clr(); idex_rs = 8; idex_rt = 9; exmem_rd = 8; memwb_rd = 9; settle();
    chk("R5 no wen a", fwd_a, 0);
    chk("R5 no wen b", fwd_b, 0);
    exmem_rd = 9; memwb_wen = 1; settle();
    chk("R5 only live memwb", fwd_b, 1);
  endtask

  task automatic t_loaduse();
    clr(); idex_load = 1; idex_wen = 1; idex_rd = 7; id_rs = 7; id_rs_ex = 1; settle();
    stall_exp("R6 rs", 1);
    id_rs = 2; id_rt = 7; id_rt_ex = 1; settle();
    stall_exp("R6 rt", 1);
    idex_wen = 0; settle();
    stall_exp("R6 no wen", 0);
  endtask

  task automatic t_store_data();
    clr(); idex_load = 1; idex_wen = 1; idex_rd = 7; id_rt = 7; id_rt_ex = 0;
    id_rs = 3; id_rs_ex = 1; settle();
    stall_exp("R7 store data", 0);
  endtask

  task automatic t_alu_prod();
    clr(); idex_wen = 1; idex_rd = 7; id_rs = 7; id_rs_ex = 1; id_rt = 7; id_rt_ex = 1; settle();
    stall_exp("R8 alu producer", 0);
  endtask

  task automatic t_store_fwd();
    clr(); exmem_store = 1; exmem_rt = 9; memwb_rd = 9; memwb_wen = 1; settle();
    chk("R9 sd from wb", fwd_sd, 1);
    exmem_store = 0; settle();
    chk("R9 not a store", fwd_sd, 0);
    exmem_store = 1; memwb_rd = 10; settle();
    chk("R9 reg mismatch", fwd_sd, 0);
    memwb_rd = 9; memwb_wen = 0; settle();
    chk("R9 no wen", fwd_sd, 0);
  endtask

  initial begin
    clr();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_idle();
    t_exmem();
    t_memwb();
    t_priority();
    t_zero();
    t_nowen();
    t_loaduse();
    t_store_data();
    t_alu_prod();
    t_store_fwd();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog got 0 expected 1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule